// File: doc/BRIEF.md
# Programmable Watchdog with Reset Steering

This block is a one-shot watchdog timer set up through a single control byte. The count advances on a slow tick input, one pulse every 1/16 second. The tick itself is produced outside the block. Software arms the timer by writing the control byte. It re-arms the timer by issuing a read strobe on the flags register. If neither happens before the programmed interval runs out, the block sets a sticky timeout flag. The steering bit of the control byte then chooses the consequence: either a one-cycle system reset request or a one-cycle interrupt pulse.

A steered expiry also clears the control byte to zero. It also clears one hold bit, bit 6, of a companion byte held in the block. System logic can use that bit to tell a watchdog restart from a cold start.

The register port is plain: a write enable with a 2-bit selector and a data byte. No data stream passes through the block, so no port carries valid/ready handshaking and none applies back-pressure. The selector codes are 0 = flags, 1 = control, 2 = companion byte, 3 = unused.

Top module: `wdog_steer`

## Requirements
- R1: After reset, ctrl_q, aux_q and wd_flag are all 0, rst_req and irq are low, and the timer is stopped.
- R2: Control byte fields: bits [6:2] are a multiplier M and bits [1:0] are a resolution S. The timer expires on the tick that completes M x 4^S ticks counted since the last arming.
- R3: A write with wr_sel = 1 stores wr_data into ctrl_q, clears wd_flag and restarts the count from zero using the new value.
- R4: A pulse on flags_rd restarts the count from zero using the stored ctrl_q and leaves wd_flag unchanged.
- R5: On expiry, wd_flag is set and stays set until the next control write.
- R6: When ctrl_q bit 7 is 1 at expiry, ctrl_q becomes 0x00, aux_q bit 6 is cleared with its other bits kept, and rst_req is high for exactly one cycle.
- R7: When ctrl_q bit 7 is 0 at expiry, irq is high for exactly one cycle and ctrl_q is unchanged.
- R8: A multiplier of zero stops the timer, and no expiry ever follows that arming.
- R9: A write with wr_sel = 0 changes nothing, because the flags register is read-only.
- R10: After an expiry the timer stays stopped, and no further expiry occurs until it is armed again.
- R11: A restart (control write or flags_rd) in the same cycle as a tick takes priority, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register select: 0 flags, 1 control, 2 companion |
| wr_data | input | 8 | Write data |
| flags_rd | input | 1 | Flags-register read strobe (restarts timer) |
| tick | input | 1 | One-cycle pulse every 1/16 s |
| ctrl_q | output | 8 | Stored control byte |
| aux_q | output | 8 | Companion byte (bit 6 is the hold bit) |
| wd_flag | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check several properties on every cycle: each output pulse lasts one cycle, reset and interrupt are never raised together, and every pulse comes with the flag set. They also check that a steered pulse coincides with a zeroed control byte and a cleared hold bit, that a control write lands and clears the flag, and that no pulse follows a zero multiplier. Other behaviour can only be shown by the bench's scenarios: the exact tick on which the interval ends for different multiplier and resolution pairs, re-arming partway through through the read strobe, the single-shot behaviour after an expiry, priority of a restart over a tick in the same cycle, and writes to the read-only flags selector having no effect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MULT_W   = 5;
  localparam int RES_W    = 2;
  localparam int NRES     = 1 << RES_W;
  localparam int LIM_W    = MULT_W + 2 * (NRES - 1);
  localparam int STEER_B  = 7;
  localparam int HOLD_B   = 6;

  typedef enum logic [1:0] {
    SEL_FLAGS = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_AUX   = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;
endpackage

// File: rtl/wd_limit.sv
module wd_limit
  import wdog_pkg::*;
(
  input  logic [MULT_W+RES_W-1:0] cfg,
  output logic [LIM_W-1:0]        limit
);
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [LIM_W-1:0]  cand [NRES];

  assign mult = cfg[MULT_W+RES_W-1:RES_W];
  assign res  = cfg[RES_W-1:0];

  // one candidate interval per resolution step (factor of four each)
  for (genvar g = 0; g < NRES; g++) begin : g_res
    assign cand[g] = LIM_W'(mult) << (2 * g);
  end

  assign limit = cand[res];
endmodule

// File: rtl/wd_counter.sv
module wd_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [LIM_W-1:0] limit_in,
  input  logic             tick,
  output logic             expire
);
  logic             running;
  logic [LIM_W-1:0] lim_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign expire  = running && tick && !arm && (cnt_inc == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      lim_q   <= '0;
      cnt_q   <= '0;
    end else if (arm) begin
      running <= (limit_in != '0);
      lim_q   <= limit_in;
      cnt_q   <= '0;
    end else if (expire) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (running && tick) begin
      cnt_q   <= cnt_inc;
    end
  end
endmodule

// File: rtl/wd_regs.sv
module wd_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       aux_wr,
  input  logic [7:0] wr_data,
  input  logic       expire,
  output logic [7:0] ctrl_q,
  output logic [7:0] aux_q,
  output logic       flag_q,
  output logic       rst_q,
  output logic       irq_q
);
  logic       steer;
  logic [7:0] aux_nxt;

  assign steer = ctrl_q[STEER_B];

  always_comb begin
    aux_nxt = aux_wr ? wr_data : aux_q;
    if (expire && steer) aux_nxt[HOLD_B] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      aux_q <= aux_nxt;
      rst_q <= expire && steer;
      irq_q <= expire && !steer;
      if (ctrl_wr) begin
        ctrl_q <= wr_data;
        flag_q <= 1'b0;
      end else if (expire) begin
        flag_q <= 1'b1;
        if (steer) ctrl_q <= '0;
      end
    end
  end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       flags_rd,
  input  logic       tick,
  output logic [7:0] ctrl_q,
  output logic [7:0] aux_q,
  output logic       wd_flag,
  output logic       rst_req,
  output logic       irq
);
  wsel_e            sel;
  logic             ctrl_wr;
  logic             aux_wr;
  logic             arm;
  logic             expire;
  logic [7:0]       cfg_src;
  logic [LIM_W-1:0] limit;

  assign sel     = wsel_e'(wr_sel);
  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign aux_wr  = wr_en && (sel == SEL_AUX);
  assign arm     = ctrl_wr || flags_rd;
  assign cfg_src = ctrl_wr ? wr_data : ctrl_q;

  wd_limit u_limit (
    .cfg   (cfg_src[MULT_W+RES_W-1:0]),
    .limit (limit)
  );

  wd_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .limit_in (limit),
    .tick     (tick),
    .expire   (expire)
  );

  wd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .aux_wr  (aux_wr),
    .wr_data (wr_data),
    .expire  (expire),
    .ctrl_q  (ctrl_q),
    .aux_q   (aux_q),
    .flag_q  (wd_flag),
    .rst_q   (rst_req),
    .irq_q   (irq)
  );
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl_q,
  input logic [7:0] aux_q,
  input logic       wd_flag,
  input logic       rst_req,
  input logic       irq
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq)); // R6
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> wd_flag); // R5
  AST_STEER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctrl_q == 8'h00) && !aux_q[6]); // R6
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> (ctrl_q == $past(wr_data)) && !wd_flag); // R3
  AST_ZERO_MULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> ($past(ctrl_q[6:2]) != 5'd0)); // R8
endmodule

bind wdog_steer wdog_steer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .ctrl_q  (ctrl_q),
  .aux_q   (aux_q),
  .wd_flag (wd_flag),
  .rst_req (rst_req),
  .irq     (irq)
);

// File: tb/wdog_steer_bench.sv
module wdog_steer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic       flags_rd = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] ctrl_q, aux_q;
  logic       wd_flag, rst_req, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int irq_cnt = 0;
  int rst_cnt = 0;
  bit done = 0;

  // reference model state
  int m_ctrl = 0, m_aux = 0, m_flag = 0, m_rst = 0, m_irq = 0;
  int m_run = 0, m_cnt = 0, m_lim = 0;

  always #5 clk = ~clk;

  wdog_steer u_wdog_steer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .flags_rd(flags_rd), .tick(tick),
    .ctrl_q(ctrl_q), .aux_q(aux_q), .wd_flag(wd_flag),
    .rst_req(rst_req), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int interval(int c);
    return ((c >> 2) & 31) * (1 << (2 * (c & 3)));
  endfunction

  // behavioural model, compared every cycle
  always @(posedge clk) begin
    int old_ctrl;
    bit cw, aw, restart, hit;
    cycles++;
    old_ctrl = m_ctrl;
    cw = wr_en && wr_sel == 2'd1;
    aw = wr_en && wr_sel == 2'd2;
    restart = cw || flags_rd;
    hit = 0;
    if (!rst_n) begin
      m_ctrl = 0; m_aux = 0; m_flag = 0; m_rst = 0; m_irq = 0;
      m_run = 0; m_cnt = 0; m_lim = 0;
    end else begin
      if (restart) begin
        m_lim = interval(cw ? int'(wr_data) : m_ctrl);
        m_run = (m_lim != 0);
        m_cnt = 0;
      end else if (m_run != 0 && tick) begin
        m_cnt++;
        if (m_cnt == m_lim) begin hit = 1; m_run = 0; m_cnt = 0; end
      end
      if (aw) m_aux = wr_data;
      m_rst = hit && old_ctrl[7];
      m_irq = hit && !old_ctrl[7];
      if (hit && old_ctrl[7]) m_aux = m_aux & 8'hBF;
      if (cw) begin m_ctrl = wr_data; m_flag = 0; end
      else if (hit) begin
        m_flag = 1;
        if (old_ctrl[7]) m_ctrl = 0;
      end
    end
    #2;
    if (rst_n) begin
      chk("R3 ctrl_q", ctrl_q, m_ctrl);
      chk("R6 aux_q", aux_q, m_aux);
      chk("R5 wd_flag", wd_flag, m_flag);
      chk("R6 rst_req", rst_req, m_rst);
      chk("R7 irq", irq, m_irq);
      if (irq) irq_cnt++;
      if (rst_req) rst_cnt++;
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic pulse_rd();
    @(negedge clk); flags_rd = 1'b1;
    @(negedge clk); flags_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 ctrl_q reset", ctrl_q, 0);
    chk("R1 aux_q reset", aux_q, 0);
    chk("R1 flag reset", wd_flag, 0);
    chk("R1 pulses reset", rst_req | irq, 0);
    rst_n = 1'b1;
    ticks(5);
    chk("R1 stopped after reset", irq_cnt + rst_cnt, 0);

    // R2 / R7: M=3, S=0, interrupt steering
    wr(2'd1, 8'h0C);
    ticks(2);
    chk("R2 no early expiry", irq_cnt, 0);
    ticks(1);
    chk("R7 irq after 3 ticks", irq_cnt, 1);
    chk("R5 flag set", wd_flag, 1);
    chk("R7 ctrl kept", ctrl_q, 8'h0C);

    // R10: one-shot
    ticks(10);
    chk("R10 no repeat", irq_cnt, 1);

    // R4: read keeps flag, restarts with stored value
    pulse_rd();
    chk("R4 flag kept on read", wd_flag, 1);
    ticks(3);
    chk("R4 re-armed expiry", irq_cnt, 2);

    // R9: write to flags selector ignored
    wr(2'd0, 8'h00);
    chk("R9 flag unchanged", wd_flag, 1);
    chk("R9 ctrl unchanged", ctrl_q, 8'h0C);

    // R2: M=2, S=1 -> 8 ticks; R3 write clears flag
    wr(2'd1, 8'h09);
    chk("R3 flag cleared", wd_flag, 0);
    ticks(7);
    chk("R2 none at 7 of 8", irq_cnt, 2);
    ticks(1);
    chk("R2 expiry at 8", irq_cnt, 3);

    // R4: mid-count restart, M=4 S=0
    wr(2'd1, 8'h10);
    ticks(3);
    pulse_rd();
    ticks(3);
    chk("R4 restart postponed", irq_cnt, 3);
    ticks(1);
    chk("R4 expiry after restart", irq_cnt, 4);

    // R6: steered to reset, M=2 S=0
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h88);
    ticks(2);
    chk("R6 reset request", rst_cnt, 1);
    chk("R6 ctrl zeroed", ctrl_q, 0);
    chk("R6 hold bit cleared", aux_q, 8'hBF);
    chk("R6 no irq", irq_cnt, 4);

    // R8: zero multiplier with max resolution
    wr(2'd1, 8'h83);
    ticks(100);
    chk("R8 zero multiplier silent", irq_cnt + rst_cnt, 5);

    // R11: restart and tick in same cycle, M=1 S=0
    base = irq_cnt;
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h04; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3; tick = 1'b0;
    chk("R11 tick ignored on restart", irq_cnt, base);
    ticks(1);
    chk("R11 next tick expires", irq_cnt, base + 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule